// File: doc/BRIEF.md
# RGB parallel LCD timing generator

This block drives a small TFT panel over a parallel RGB bus. It runs on the dot clock and uses two counters, one per axis, to produce horizontal sync, vertical sync and data-enable. It also outputs a pixel clock whose edge sense can be set. During a programmable pixel window it reads 16-bit RGB565 pixels from a line buffer with a one-cycle read latency. It widens each pixel to the 18-bit RGB666 bus.

Each axis is programmed with cumulative boundary values. These are:

- sync end: pulse width minus one
- porch end: sync end plus back porch
- active end: porch end plus active size
- line/frame end: active end plus front porch

Normally the window runs from porch end plus one to porch end plus the panel size. Timing and window writes land in shadow registers. They reach the counters only when a reload strobe is given. Polarity writes act at once. A global enable holds the counters at zero and parks every output at its inactive level. Reset values come from the panel parameters.

Top module: `lcd_timing_gen`

## Requirements
- R1: The horizontal counter runs from 0 to the line-end value and then wraps. The line period is line-end + 1 cycles, and HSYNC is active while the counter is at most sync-end.
- R2: The vertical counter advances only when the horizontal counter wraps. It wraps after frame-end. A frame is frame-end + 1 lines, and VSYNC is active for sync-end + 1 lines.
- R3: DE is active when both counters lie above porch-end and at or below active-end. HSYNC, VSYNC, DE and RGB all leave the block with the same latency, so DE starts HSYNC_W + H_BACK cycles after the start of HSYNC.
- R4: pix_req is high for each position inside the window, on both axes from window-low to window-high inclusive. It comes with pix_col = h - window-low and pix_row = v - window-low. The returned pixel is expected on pix_data one cycle after pix_req.
- R5: A pixel with red in [15:11], green in [10:5] and blue in [4:0] is driven as red {r, r[4]} on lcd_rgb[17:12], green unchanged on [11:6], and blue {b, b[4]} on [5:0].
- R6: lcd_rgb is zero at every position outside the window, including active positions.
- R7: Configuration writes use cfg_addr 0 (sync end), 1 (porch end), 2 (active end), 3 (line/frame end), 4 (window low) and 5 (window high). The horizontal value is on cfg_wdata[11:0] and the vertical value on cfg_wdata[23:12]. These writes have no effect on the outputs until a cfg_reload pulse copies them to the working set.
- R8: cfg_addr 6 writes the polarity bits cfg_wdata[3:0] at once: bit 0 HSYNC, bit 1 VSYNC, bit 2 DE, bit 3 pixel clock. A 0 makes a signal active low and leaves lcd_pclk in phase with clk. A 1 makes the signal active high and inverts lcd_pclk.
- R9: While enable is low, the following hold from the next cycle on:
  - the counters rest at zero
  - HSYNC, VSYNC and DE sit at their inactive level
  - lcd_rgb is zero
  - pix_req is low
  - lcd_pclk is low
- R10: After reset the polarity bits are 0 and the timing and window values are the ones built from the panel and porch parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global run enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 2*TG_CW | Horizontal value low lane, vertical value high lane |
| cfg_reload | input | 1 | Copy shadow timing to working set |
| pix_req | output | 1 | Line-buffer read request |
| pix_col | output | TG_CW | Column within the window |
| pix_row | output | TG_CW | Row within the window |
| pix_data | input | 16 | RGB565 pixel, one cycle after request |
| lcd_pclk | output | 1 | Panel pixel clock |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_de | output | 1 | Data enable |
| lcd_rgb | output | 18 | RGB666 pixel bus |

## Verification
Two events fall in the same cycle at every line end: the horizontal wrap and the vertical step. The last line of a frame also adds the vertical wrap. The bench checks two back-to-back frames position by position, using a reference position built from the sync edges, so any slip at the line or frame boundary shows up in the second frame. A line-buffer model returns a pattern coded by column and row, and the window test moves the window off the active edges. Together these show that the request address and the returned pixel land in the same output cycle as DE and the syncs.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  parameter int unsigned TG_CW = 12;

  typedef logic [TG_CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t sync_end;
    cnt_t porch_end;
    cnt_t act_end;
    cnt_t line_end;
    cnt_t win_lo;
    cnt_t win_hi;
  } axis_cfg_t;

  typedef struct packed {
    logic sync;
    logic act;
    logic win;
  } axis_flags_t;

  typedef enum logic [2:0] {
    A_SYNC  = 3'd0,
    A_PORCH = 3'd1,
    A_ACT   = 3'd2,
    A_TOTAL = 3'd3,
    A_WLO   = 3'd4,
    A_WHI   = 3'd5,
    A_POL   = 3'd6
  } cfg_addr_e;

  localparam int unsigned AX_H   = 0;
  localparam int unsigned AX_V   = 1;
  localparam int unsigned NUM_AX = 2;

  localparam int unsigned POL_HS = 0;
  localparam int unsigned POL_VS = 1;
  localparam int unsigned POL_DE = 2;
  localparam int unsigned POL_CK = 3;

  function automatic axis_flags_t decode_axis(input cnt_t c, input axis_cfg_t a);
    axis_flags_t f;
    f.sync = (c <= a.sync_end);
    f.act  = (c > a.porch_end) && (c <= a.act_end);
    f.win  = (c >= a.win_lo) && (c <= a.win_hi);
    return f;
  endfunction

  function automatic logic [17:0] rgb565_to_666(input logic [15:0] p);
    return {p[15:11], p[15], p[10:5], p[4:0], p[4]};
  endfunction
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter axis_cfg_t H_INIT = '0,
  parameter axis_cfg_t V_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [2*TG_CW-1:0]   cfg_wdata,
  input  logic                 cfg_reload,
  output axis_cfg_t            h_cfg,
  output axis_cfg_t            v_cfg,
  output logic [3:0]           pol
);
  for (genvar ax = 0; ax < NUM_AX; ax++) begin : g_ax
    localparam axis_cfg_t INIT = (ax == AX_H) ? H_INIT : V_INIT;
    axis_cfg_t shadow_q;
    axis_cfg_t active_q;
    cnt_t      lane;

    assign lane = cfg_wdata[ax*TG_CW +: TG_CW];

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= INIT;
        active_q <= INIT;
      end else begin
        if (cfg_we) begin
          case (cfg_addr)
            A_SYNC:  shadow_q.sync_end  <= lane;
            A_PORCH: shadow_q.porch_end <= lane;
            A_ACT:   shadow_q.act_end   <= lane;
            A_TOTAL: shadow_q.line_end  <= lane;
            A_WLO:   shadow_q.win_lo    <= lane;
            A_WHI:   shadow_q.win_hi    <= lane;
            default: ;
          endcase
        end
        if (cfg_reload) active_q <= shadow_q;
      end
    end
  end

  assign h_cfg = g_ax[AX_H].active_q;
  assign v_cfg = g_ax[AX_V].active_q;

  always_ff @(posedge clk) begin
    if (rst)                                  pol <= '0;
    else if (cfg_we && (cfg_addr == A_POL))   pol <= cfg_wdata[3:0];
  end
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic step,
  input  cnt_t last_val,
  output cnt_t cnt,
  output logic at_end
);
  // >= rather than == so a reload that shrinks the period cannot strand the count
  assign at_end = (cnt >= last_val);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (step)    cnt <= at_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/lcd_tg_decode.sv
module lcd_tg_decode
  import lcd_tg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  cnt_t      h_cnt,
  input  cnt_t      v_cnt,
  input  axis_cfg_t h_cfg,
  input  axis_cfg_t v_cfg,
  output logic      pix_req,
  output cnt_t      pix_col,
  output cnt_t      pix_row,
  output logic      hs_d,
  output logic      vs_d,
  output logic      de_d,
  output logic      win_d,
  output logic      en_d
);
  axis_flags_t hf, vf;
  logic        in_win;
  logic        s1_hs, s1_vs, s1_de, s1_en;

  assign hf     = decode_axis(h_cnt, h_cfg);
  assign vf     = decode_axis(v_cnt, v_cfg);
  assign in_win = hf.win && vf.win;

  // stage 1: request to the line buffer and decoded flags
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      s1_hs   <= 1'b0;
      s1_vs   <= 1'b0;
      s1_de   <= 1'b0;
      s1_en   <= 1'b0;
      pix_req <= 1'b0;
      pix_col <= '0;
      pix_row <= '0;
    end else begin
      s1_hs   <= hf.sync;
      s1_vs   <= vf.sync;
      s1_de   <= hf.act && vf.act;
      s1_en   <= 1'b1;
      pix_req <= in_win;
      pix_col <= in_win ? cnt_t'(h_cnt - h_cfg.win_lo) : '0;
      pix_row <= in_win ? cnt_t'(v_cnt - v_cfg.win_lo) : '0;
    end
  end

  // stage 2: flags wait while the line buffer answers
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hs_d  <= 1'b0;
      vs_d  <= 1'b0;
      de_d  <= 1'b0;
      win_d <= 1'b0;
      en_d  <= 1'b0;
    end else begin
      hs_d  <= s1_hs;
      vs_d  <= s1_vs;
      de_d  <= s1_de;
      win_d <= pix_req;
      en_d  <= s1_en;
    end
  end
endmodule

// File: rtl/lcd_tg_pixout.sv
module lcd_tg_pixout
  import lcd_tg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [3:0]  pol,
  input  logic        hs,
  input  logic        vs,
  input  logic        de,
  input  logic        win,
  input  logic        en_d,
  input  logic [15:0] pix_data,
  output logic        lcd_hsync,
  output logic        lcd_vsync,
  output logic        lcd_de,
  output logic [17:0] lcd_rgb,
  output logic        out_en
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lcd_hsync <= ~pol[POL_HS];
      lcd_vsync <= ~pol[POL_VS];
      lcd_de    <= ~pol[POL_DE];
      lcd_rgb   <= '0;
      out_en    <= 1'b0;
    end else begin
      lcd_hsync <= hs  ? pol[POL_HS] : ~pol[POL_HS];
      lcd_vsync <= vs  ? pol[POL_VS] : ~pol[POL_VS];
      lcd_de    <= de  ? pol[POL_DE] : ~pol[POL_DE];
      lcd_rgb   <= win ? rgb565_to_666(pix_data) : '0;
      out_en    <= en_d;
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned PANEL_W = 320,
  parameter int unsigned PANEL_H = 240,
  parameter int unsigned HSYNC_W = 10,
  parameter int unsigned H_BACK  = 20,
  parameter int unsigned H_FRONT = 10,
  parameter int unsigned VSYNC_H = 2,
  parameter int unsigned V_BACK  = 2,
  parameter int unsigned V_FRONT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [2*TG_CW-1:0] cfg_wdata,
  input  logic               cfg_reload,
  output logic               pix_req,
  output logic [TG_CW-1:0]   pix_col,
  output logic [TG_CW-1:0]   pix_row,
  input  logic [15:0]        pix_data,
  output logic               lcd_pclk,
  output logic               lcd_hsync,
  output logic               lcd_vsync,
  output logic               lcd_de,
  output logic [17:0]        lcd_rgb
);
  localparam int unsigned H_SYNC_END  = HSYNC_W - 1;
  localparam int unsigned H_PORCH_END = H_SYNC_END + H_BACK;
  localparam int unsigned H_ACT_END   = H_PORCH_END + PANEL_W;
  localparam int unsigned H_LINE_END  = H_ACT_END + H_FRONT;
  localparam int unsigned V_SYNC_END  = VSYNC_H - 1;
  localparam int unsigned V_PORCH_END = V_SYNC_END + V_BACK;
  localparam int unsigned V_ACT_END   = V_PORCH_END + PANEL_H;
  localparam int unsigned V_LINE_END  = V_ACT_END + V_FRONT;

  localparam axis_cfg_t H_INIT = '{
    sync_end:  cnt_t'(H_SYNC_END),  porch_end: cnt_t'(H_PORCH_END),
    act_end:   cnt_t'(H_ACT_END),   line_end:  cnt_t'(H_LINE_END),
    win_lo:    cnt_t'(H_PORCH_END + 1), win_hi: cnt_t'(H_ACT_END)};
  localparam axis_cfg_t V_INIT = '{
    sync_end:  cnt_t'(V_SYNC_END),  porch_end: cnt_t'(V_PORCH_END),
    act_end:   cnt_t'(V_ACT_END),   line_end:  cnt_t'(V_LINE_END),
    win_lo:    cnt_t'(V_PORCH_END + 1), win_hi: cnt_t'(V_ACT_END)};

  axis_cfg_t  h_cfg, v_cfg;
  logic [3:0] pol;
  cnt_t       h_cnt, v_cnt;
  logic       h_last, v_last;
  logic       hs_d, vs_d, de_d, win_d, en_d;
  logic       out_en;

  lcd_tg_regs #(.H_INIT(H_INIT), .V_INIT(V_INIT)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_reload(cfg_reload),
    .h_cfg(h_cfg), .v_cfg(v_cfg), .pol(pol));

  lcd_tg_axis u_hcnt (
    .clk(clk), .rst(rst), .run(enable), .step(1'b1),
    .last_val(h_cfg.line_end), .cnt(h_cnt), .at_end(h_last));

  lcd_tg_axis u_vcnt (
    .clk(clk), .rst(rst), .run(enable), .step(h_last),
    .last_val(v_cfg.line_end), .cnt(v_cnt), .at_end(v_last));

  lcd_tg_decode u_dec (
    .clk(clk), .rst(rst), .en(enable), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .h_cfg(h_cfg), .v_cfg(v_cfg), .pix_req(pix_req), .pix_col(pix_col),
    .pix_row(pix_row), .hs_d(hs_d), .vs_d(vs_d), .de_d(de_d),
    .win_d(win_d), .en_d(en_d));

  lcd_tg_pixout u_out (
    .clk(clk), .rst(rst), .en(enable), .pol(pol), .hs(hs_d), .vs(vs_d),
    .de(de_d), .win(win_d), .en_d(en_d), .pix_data(pix_data),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
    .lcd_rgb(lcd_rgb), .out_en(out_en));

  // pixel clock leaves the block as the dot clock, optionally inverted
  assign lcd_pclk = out_en & (clk ^ pol[POL_CK]);
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk
  import lcd_tg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic        pix_req,
  input logic [15:0] pix_data,
  input logic [17:0] lcd_rgb,
  input cnt_t        hcnt,
  input cnt_t        vcnt,
  input logic        h_last,
  input logic        v_last
);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!pix_req && lcd_rgb == '0));

  // R5
  expand_path_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(enable) && $past(enable, 2) && $past(pix_req, 2))
      |-> (lcd_rgb == rgb565_to_666($past(pix_data))));

  // R6
  win_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(enable) && $past(enable, 2) && !$past(pix_req, 2))
      |-> (lcd_rgb == '0));

  // R2
  v_step_chk: assert property (@(posedge clk) disable iff (rst)
    (vcnt != $past(vcnt)) |-> (hcnt == '0));

  // R2
  v_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && h_last && v_last) |=> (vcnt == '0 && hcnt == '0));
endmodule

bind lcd_timing_gen lcd_tg_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .pix_req(pix_req),
  .pix_data(pix_data), .lcd_rgb(lcd_rgb), .hcnt(h_cnt), .vcnt(v_cnt),
  .h_last(h_last), .v_last(v_last));

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  import lcd_tg_pkg::*;

  localparam int CLK_P = 10;
  localparam int W = 8, H = 4, HSW = 2, HBP = 3, HFP = 2, VSW = 2, VBP = 2, VFP = 2;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic cfg_we = 1'b0, cfg_reload = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [2*TG_CW-1:0] cfg_wdata = '0;
  logic pix_req;
  logic [TG_CW-1:0] pix_col, pix_row;
  logic [15:0] pix_data = '0;
  logic lcd_pclk, lcd_hsync, lcd_vsync, lcd_de;
  logic [17:0] lcd_rgb;

  int checks = 0, errors = 0;
  bit done = 0;
  int c_hs, c_hbp, c_hact, c_htot, c_hwl, c_hwh;
  int c_vs, c_vbp, c_vact, c_vtot, c_vwl, c_vwh;
  logic [3:0] c_pol;

  lcd_timing_gen #(.PANEL_W(W), .PANEL_H(H), .HSYNC_W(HSW), .H_BACK(HBP), .H_FRONT(HFP),
                   .VSYNC_H(VSW), .V_BACK(VBP), .V_FRONT(VFP)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_reload(cfg_reload), .pix_req(pix_req),
    .pix_col(pix_col), .pix_row(pix_row), .pix_data(pix_data), .lcd_pclk(lcd_pclk),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .lcd_rgb(lcd_rgb));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] pat(int col, int row);
    return {1'b1, 4'(row), 6'(col), 5'b10101};
  endfunction

  function automatic logic [17:0] widen(logic [15:0] p);
    return {p[15:11], p[15], p[10:5], p[4:0], p[4]};
  endfunction

  function automatic logic lvl(bit act, logic p);
    return act ? p : ~p;
  endfunction

  // line buffer model: one-cycle read latency
  always @(posedge clk) if (pix_req) pix_data <= pat(int'(pix_col), int'(pix_row));

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(int addr, int hval, int vval);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = {TG_CW'(vval), TG_CW'(hval)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reload_pulse();
    @(negedge clk); cfg_reload = 1'b1;
    @(negedge clk); cfg_reload = 1'b0;
  endtask

  task automatic load_defaults();
    c_hs = HSW-1; c_hbp = c_hs+HBP; c_hact = c_hbp+W; c_htot = c_hact+HFP;
    c_hwl = c_hbp+1; c_hwh = c_hact;
    c_vs = VSW-1; c_vbp = c_vs+VBP; c_vact = c_vbp+H; c_vtot = c_vact+VFP;
    c_vwl = c_vbp+1; c_vwh = c_vact;
    c_pol = 4'h0;
  endtask

  // Checks one whole frame against a position model anchored at the VSYNC start
  task automatic check_frame(string scen);
    int period = c_htot + 1;
    int total  = period * (c_vtot + 1);
    int nerr[4];
    longint fa[4], fe[4];
    int reqs = 0;
    bit prev, cur, hit;
    for (int k = 0; k < 4; k++) begin nerr[k] = 0; fa[k] = 0; fe[k] = 0; end
    @(negedge clk);
    prev = (lcd_vsync == c_pol[1]);
    do begin
      @(negedge clk);
      cur = (lcd_vsync == c_pol[1]);
      hit = cur && !prev;
      prev = cur;
    end while (!hit);
    for (int i = 0; i < total; i++) begin
      int x = i % period;
      int y = i / period;
      bit e_de  = (x > c_hbp) && (x <= c_hact) && (y > c_vbp) && (y <= c_vact);
      bit e_win = (x >= c_hwl) && (x <= c_hwh) && (y >= c_vwl) && (y <= c_vwh);
      logic [17:0] e_rgb = e_win ? widen(pat(x - c_hwl, y - c_vwl)) : 18'h0;
      logic e_h = lvl(x <= c_hs, c_pol[0]);
      logic e_v = lvl(y <= c_vs, c_pol[1]);
      logic e_d = lvl(e_de, c_pol[2]);
      if (lcd_hsync !== e_h) begin if (nerr[0] == 0) begin fa[0] = lcd_hsync; fe[0] = e_h; end nerr[0]++; end
      if (lcd_vsync !== e_v) begin if (nerr[1] == 0) begin fa[1] = lcd_vsync; fe[1] = e_v; end nerr[1]++; end
      if (lcd_de    !== e_d) begin if (nerr[2] == 0) begin fa[2] = lcd_de;    fe[2] = e_d; end nerr[2]++; end
      if (lcd_rgb   !== e_rgb) begin if (nerr[3] == 0) begin fa[3] = lcd_rgb; fe[3] = e_rgb; end nerr[3]++; end
      if (pix_req) reqs++;
      if (i != total - 1) @(negedge clk);
    end
    chk(nerr[0] == 0, {scen, " R1 hsync"}, fa[0], fe[0]);
    chk(nerr[1] == 0, {scen, " R2 vsync"}, fa[1], fe[1]);
    chk(nerr[2] == 0, {scen, " R3 de"}, fa[2], fe[2]);
    chk(nerr[3] == 0, {scen, " R4 R5 R6 rgb"}, fa[3], fe[3]);
    chk(reqs == (c_hwh-c_hwl+1)*(c_vwh-c_vwl+1), {scen, " R4 request count"},
        reqs, (c_hwh-c_hwl+1)*(c_vwh-c_vwl+1));
  endtask

  task automatic t_reset();
    rst = 1'b1; enable = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(lcd_hsync === 1'b1, "R10 R9 hsync idle", lcd_hsync, 1);
    chk(lcd_vsync === 1'b1, "R10 R9 vsync idle", lcd_vsync, 1);
    chk(lcd_de === 1'b1, "R10 R9 de idle", lcd_de, 1);
    chk(lcd_rgb === 18'h0, "R9 rgb idle", lcd_rgb, 0);
    chk(pix_req === 1'b0, "R9 no request", pix_req, 0);
    chk(lcd_pclk === 1'b0, "R9 pclk idle", lcd_pclk, 0);
  endtask

  task automatic t_default();
    load_defaults();
    @(negedge clk); enable = 1'b1;
    check_frame("R10 default f0");
    check_frame("R2 default f1");
    @(negedge clk);
    chk(lcd_pclk === 1'b0, "R8 pclk low phase", lcd_pclk, 0);
    @(posedge clk); #1;
    chk(lcd_pclk === 1'b1, "R8 pclk high phase", lcd_pclk, 1);
  endtask

  task automatic t_shadow();
    @(negedge clk); enable = 1'b0;
    wr(0, c_hs + 1, c_vs);
    @(negedge clk); enable = 1'b1;
    check_frame("R7 pending");
    @(negedge clk); enable = 1'b0;
    reload_pulse();
    c_hs = c_hs + 1;
    @(negedge clk); enable = 1'b1;
    check_frame("R7 applied");
  endtask

  task automatic t_window();
    @(negedge clk); enable = 1'b0;
    wr(4, c_hbp + 2, c_vbp + 2);
    wr(5, c_hbp + 5, c_vbp + 3);
    reload_pulse();
    c_hwl = c_hbp + 2; c_hwh = c_hbp + 5; c_vwl = c_vbp + 2; c_vwh = c_vbp + 3;
    @(negedge clk); enable = 1'b1;
    check_frame("R4 R6 window");
  endtask

  task automatic t_polarity();
    @(negedge clk); enable = 1'b0;
    wr(6, 15, 0);
    c_pol = 4'hF;
    @(negedge clk); enable = 1'b1;
    check_frame("R8 polarity");
    @(negedge clk);
    chk(lcd_pclk === 1'b1, "R8 inverted pclk low phase", lcd_pclk, 1);
    @(posedge clk); #1;
    chk(lcd_pclk === 1'b0, "R8 inverted pclk high phase", lcd_pclk, 0);
  endtask

  task automatic t_disable();
    int bad = 0;
    repeat (37) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      if (lcd_hsync !== ~c_pol[0] || lcd_vsync !== ~c_pol[1] || lcd_de !== ~c_pol[2] ||
          lcd_rgb !== 18'h0 || pix_req !== 1'b0 || lcd_pclk !== 1'b0) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 outputs parked while disabled", bad, 0);
    chk(lcd_hsync === ~c_pol[0], "R9 hsync parked level", lcd_hsync, ~c_pol[0]);
    enable = 1'b1;
    check_frame("R9 restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default();
    t_shadow();
    t_window();
    t_polarity();
    t_disable();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule